// File: doc/BRIEF.md
# Quad-Channel DAC Serial Command Core

This block is the digital side of a four-channel, 8-bit converter. A host sends 12-bit command words over a three-wire serial link: an active-low select, a serial clock and a data line. The block samples the link with a fast system clock. Each channel has two stages of storage. An input latch holds a code that has been written but not yet applied. A DAC latch holds the code that drives the converter. Code 00 hex gives zero output and FF hex gives full scale. A command is decoded only once the select line returns high.

Two asynchronous active-low pins act beside the serial link. The load pin copies every input latch into its DAC latch for as long as it is held low. The clear pin zeroes both stages at once. Special commands do three other jobs: they drive a general-purpose logic output, they request shutdown (honoured only while the enable pin is high), and they choose which serial clock edge launches the serial output. The serial output repeats the received bit stream one word later, so that several devices can be chained.

Top module: `quad_dac_ctrl`

## Requirements
- R1: After a synchronous reset, `dac_code`, `upo`, `shdn` and `dout` are all zero, and the serial output launches on the falling edge.
- R2: A word is 12 bits, most significant bit first. Bits [11:10] are the channel address (0 = A through 3 = D). Bits [9:8] are the operation. Bits [7:0] are the data. Bits are taken on rising `sclk` edges only while `cs_n` is low. If more than 12 bits arrive, the last 12 are used.
- R3: No latch or output changes while a word is arriving. A word is executed on the rise of `cs_n`. If fewer than 12 bits arrived, the word is discarded.
- R4: Operation 01 writes the data into the addressed input latch only. `dac_code` does not change.
- R5: Operation 10 copies all four input latches into their DAC latches. Its data field is ignored.
- R6: Operation 11 writes the addressed input latch and then copies all input latches to the DAC latches, so the new code appears at once.
- R7: While `ldac_n` is low, every DAC latch follows its input latch. A word that executes while `ldac_n` is low reaches `dac_code`.
- R8: Driving `clr_n` low zeroes every input latch and every DAC latch with no clock edge needed.
- R9: Operation 00 with address 2 sets `upo` to data bit 0. Operation 00 with address 0 changes nothing.
- R10: Operation 00 with address 1 sets `shdn` only when `pde` is high, and is ignored when `pde` is low. Any word with operation 01, 10 or 11 clears `shdn`.
- R11: At each rising `sclk` edge, `dout` shows the bit received on `din` 12 rising edges earlier. `dout` holds its value while `cs_n` is high.
- R12: Operation 00 with address 3 selects the launch edge of `dout`: data bit 0 = 1 selects the rising `sclk` edge, and 0 selects the falling edge.

`dac_code` places channel i in bits [8i+7:8i].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| ldac_n | input | 1 | Load all DAC latches, active low, level sensitive |
| clr_n | input | 1 | Asynchronous clear of all latches, active low |
| pde | input | 1 | Enable for the shutdown command |
| dout | output | 1 | Serial data out, delayed by one word |
| upo | output | 1 | Software-set logic output |
| shdn | output | 1 | Shutdown request |
| dac_code | output | 32 | DAC latch contents, channel A in the low byte |

## Verification
Consider a word, and call the first `clk` edge that samples `cs_n` high edge one. The word's effect on `dac_code`, `upo` and `shdn` becomes visible after the fourth such edge. A low `ldac_n` reaches `dac_code` after the third edge. `clr_n` takes effect with no edge at all. A selected `sclk` edge moves `dout` after the third `clk` edge. The driver holds each `sclk` level for 8 cycles and samples `dout` at the end of each half period. The monitor compares each queued command result 10 cycles after the push. The clear is checked one nanosecond after `clr_n` falls, before any clock edge.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  typedef enum logic [1:0] {
    OP_SPECIAL  = 2'b00,
    OP_LOAD     = 2'b01,
    OP_UPDATE   = 2'b10,
    OP_LOAD_UPD = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    SF_NOP  = 2'b00,
    SF_SHDN = 2'b01,
    SF_GPO  = 2'b10,
    SF_EDGE = 2'b11
  } sf_e;
endpackage

// File: rtl/qdac_sync.sv
module qdac_sync #(
  parameter int         W      = 1,
  parameter int         STAGES = 2,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) pipe[i] <= INIT;
    end else begin
      pipe[0] <= d;
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/qdac_serial.sv
module qdac_serial #(
  parameter int WORD_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n_s,
  input  logic              sclk_s,
  input  logic              din_s,
  input  logic              edge_rise,
  output logic              cmd_valid,
  output logic [WORD_W-1:0] cmd_word,
  output logic              dout
);
  localparam int CNT_W = $clog2(WORD_W + 1);

  logic              sclk_q, cs_q;
  logic [WORD_W-1:0] sr;
  logic [CNT_W-1:0]  cnt;
  logic              sclk_up, sclk_dn, active, cs_rise;

  assign sclk_up = sclk_s & ~sclk_q;
  assign sclk_dn = ~sclk_s & sclk_q;
  assign active  = ~cs_n_s;
  assign cs_rise = cs_n_s & ~cs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
      sr        <= '0;
      cnt       <= '0;
      dout      <= 1'b0;
      cmd_valid <= 1'b0;
      cmd_word  <= '0;
    end else begin
      sclk_q    <= sclk_s;
      cs_q      <= cs_n_s;
      cmd_valid <= 1'b0;
      if (active && sclk_up) begin
        sr <= {sr[WORD_W-2:0], din_s};
        if (cnt != CNT_W'(WORD_W)) cnt <= cnt + 1'b1;
        if (edge_rise) dout <= sr[WORD_W-2];
      end
      if (active && sclk_dn && !edge_rise) dout <= sr[WORD_W-1];
      if (cs_rise) begin
        cmd_valid <= (cnt == CNT_W'(WORD_W));
        cmd_word  <= sr;
        cnt       <= '0;
      end
    end
  end

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(WORD_W));

  p_no_shift_idle_r2: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> $stable(sr));

  p_dout_hold_r11: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> $stable(dout));
endmodule

// File: rtl/qdac_regs.sv
module qdac_regs
  import qdac_pkg::*;
#(
  parameter int AW = 2,
  parameter int DW = 8,
  localparam int NCH    = 1 << AW,
  localparam int WORD_W = AW + 2 + DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr_n,
  input  logic              cmd_valid,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic              ldac_n_s,
  input  logic              pde_s,
  output logic [NCH*DW-1:0] dac_flat,
  output logic              upo,
  output logic              shdn,
  output logic              edge_rise
);
  logic [DW-1:0] in_lat  [NCH];
  logic [DW-1:0] dac_lat [NCH];
  logic [DW-1:0] in_nxt  [NCH];
  logic [NCH*DW-1:0] in_flat;
  logic [AW-1:0] addr;
  logic [DW-1:0] data;
  op_e           op;
  logic          wr_in, upd_all;

  assign addr    = cmd_word[WORD_W-1 -: AW];
  assign op      = op_e'(cmd_word[DW +: 2]);
  assign data    = cmd_word[DW-1:0];
  assign wr_in   = cmd_valid && (op == OP_LOAD || op == OP_LOAD_UPD);
  assign upd_all = (cmd_valid && (op == OP_UPDATE || op == OP_LOAD_UPD)) || !ldac_n_s;

  always_comb begin
    for (int i = 0; i < NCH; i++) begin
      in_nxt[i] = in_lat[i];
      if (wr_in && addr == AW'(i)) in_nxt[i] = data;
    end
  end

  always_ff @(posedge clk or negedge clr_n) begin
    if (!clr_n) begin
      for (int i = 0; i < NCH; i++) begin
        in_lat[i]  <= '0;
        dac_lat[i] <= '0;
      end
    end else if (rst) begin
      for (int i = 0; i < NCH; i++) begin
        in_lat[i]  <= '0;
        dac_lat[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NCH; i++) begin
        in_lat[i] <= in_nxt[i];
        if (upd_all) dac_lat[i] <= in_nxt[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upo       <= 1'b0;
      shdn      <= 1'b0;
      edge_rise <= 1'b0;
    end else if (cmd_valid) begin
      if (op == OP_SPECIAL) begin
        case (sf_e'(addr[1:0]))
          SF_SHDN: if (pde_s) shdn <= 1'b1;
          SF_GPO:  upo       <= data[0];
          SF_EDGE: edge_rise <= data[0];
          default: ;
        endcase
      end else begin
        shdn <= 1'b0;
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_flat
    assign dac_flat[g*DW +: DW] = dac_lat[g];
    assign in_flat[g*DW +: DW]  = in_lat[g];
  end

  p_clr_zero_r8: assert property (@(posedge clk) disable iff (rst)
    !clr_n |-> (dac_flat == '0 && in_flat == '0));

  p_ldac_follow_r7: assert property (@(posedge clk) disable iff (rst)
    !ldac_n_s |=> (dac_flat == in_flat));

  p_load_keeps_dac_r4: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_LOAD && ldac_n_s) |=> ($stable(dac_flat) || dac_flat == '0));

  p_shdn_gated_r10: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && op == OP_SPECIAL && addr == AW'(1) && !pde_s) |=> $stable(shdn));
endmodule

// File: rtl/quad_dac_ctrl.sv
module quad_dac_ctrl #(
  parameter int AW          = 2,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2,
  localparam int NCH    = 1 << AW,
  localparam int WORD_W = AW + 2 + DW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              ldac_n,
  input  logic              clr_n,
  input  logic              pde,
  output logic              dout,
  output logic              upo,
  output logic              shdn,
  output logic [NCH*DW-1:0] dac_code
);
  logic [4:0]        raw, syn;
  logic              cmd_valid, edge_rise;
  logic [WORD_W-1:0] cmd_word;

  assign raw = {cs_n, sclk, din, ldac_n, pde};

  qdac_sync #(.W(5), .STAGES(SYNC_STAGES), .INIT(5'b10010)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (raw),
    .q   (syn)
  );

  qdac_serial #(.WORD_W(WORD_W)) u_serial (
    .clk       (clk),
    .rst       (rst),
    .cs_n_s    (syn[4]),
    .sclk_s    (syn[3]),
    .din_s     (syn[2]),
    .edge_rise (edge_rise),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .dout      (dout)
  );

  qdac_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .clr_n     (clr_n),
    .cmd_valid (cmd_valid),
    .cmd_word  (cmd_word),
    .ldac_n_s  (syn[1]),
    .pde_s     (syn[0]),
    .dac_flat  (dac_code),
    .upo       (upo),
    .shdn      (shdn),
    .edge_rise (edge_rise)
  );
endmodule

// File: tb/quad_dac_ctrl_tb.sv
`timescale 1ns/1ps
module quad_dac_ctrl_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, ldac_n = 1'b1, clr_n = 1'b1, pde = 1'b0;
  logic dout, upo, shdn;
  logic [31:0] dac_code;

  quad_dac_ctrl u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
    .ldac_n(ldac_n), .clr_n(clr_n), .pde(pde),
    .dout(dout), .upo(upo), .shdn(shdn), .dac_code(dac_code)
  );

  always #2 clk = ~clk;

  typedef struct {
    logic [31:0] dac;
    logic        upo;
    logic        shdn;
    string       req;
  } exp_t;

  exp_t q[$];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;
  logic [7:0] m_in [4];
  logic [7:0] m_dac [4];
  logic m_upo = 1'b0, m_shdn = 1'b0;
  logic pre_s [16];
  logic mid_s [16];
  logic [31:0] pre_cs_dac;

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] m_flat();
    return {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
  endfunction

  task automatic send_bits(input logic [15:0] w, input int n);
    cs_n = 1'b0;
    step(8);
    for (int k = 0; k < n; k++) begin
      din = w[n-1-k];
      step(8);
      pre_s[k] = dout;
      sclk = 1'b1;
      step(8);
      mid_s[k] = dout;
      sclk = 1'b0;
    end
    step(8);
    pre_cs_dac = dac_code;
    cs_n = 1'b1;
    step(4);
  endtask

  task automatic model(input logic [11:0] w);
    logic [1:0] a, op;
    logic [7:0] d;
    a = w[11:10]; op = w[9:8]; d = w[7:0];
    if (op == 2'b01 || op == 2'b11) m_in[a] = d;
    if (op == 2'b10 || op == 2'b11) for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    if (op == 2'b00) begin
      if (a == 2'd1 && pde) m_shdn = 1'b1;
      if (a == 2'd2) m_upo = d[0];
    end else m_shdn = 1'b0;
    if (!ldac_n) for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
  endtask

  task automatic push(input string req);
    exp_t e;
    e.dac = m_flat(); e.upo = m_upo; e.shdn = m_shdn; e.req = req;
    q.push_back(e);
    step(14);
  endtask

  task automatic send_cmd(input logic [11:0] w, input string req);
    send_bits({4'h0, w}, 12);
    model(w);
    push(req);
  endtask

  // monitor: compares queued expectations once results are due
  initial begin
    exp_t e;
    forever begin
      while (q.size() == 0) @(negedge clk);
      repeat (10) @(negedge clk);
      e = q.pop_front();
      chk({e.req, " dac_code"}, dac_code, e.dac);
      chk({e.req, " upo"}, upo, e.upo);
      chk({e.req, " shdn"}, shdn, e.shdn);
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] w1, w2;
    for (int i = 0; i < 4; i++) begin m_in[i] = 8'h00; m_dac[i] = 8'h00; end
    step(10);
    rst = 1'b0;
    step(4);
    // R1 reset state
    chk("R1 dac_code", dac_code, 0);
    chk("R1 upo", upo, 0);
    chk("R1 shdn", shdn, 0);
    chk("R1 dout", dout, 0);

    // R4 load input latch only
    send_cmd({2'd0, 2'b01, 8'h5A}, "R4 load A");
    send_cmd({2'd2, 2'b01, 8'hC3}, "R4 load C");
    // R5 update all, data ignored
    send_cmd({2'd0, 2'b10, 8'hFF}, "R5 update");
    // R6 load and update
    send_cmd({2'd3, 2'b11, 8'h81}, "R6 load+update D");

    // R3 no change mid-frame, then applied on CS rise
    send_bits({4'h0, 2'd1, 2'b11, 8'h7E}, 12);
    chk("R3 mid-frame dac", pre_cs_dac, m_flat());
    model({2'd1, 2'b11, 8'h7E});
    push("R3 executed on cs rise");
    // R3 short word discarded
    send_bits({9'h0, 7'h55}, 7);
    push("R3 short word");

    // R2 extra leading bits dropped
    send_bits({4'hF, 2'd1, 2'b11, 8'h3C}, 16);
    model({2'd1, 2'b11, 8'h3C});
    push("R2 long word");

    // R2 / R11 sclk activity with cs_n high is ignored
    begin
      logic d0;
      d0 = dout;
      din = 1'b1;
      for (int k = 0; k < 5; k++) begin sclk = 1'b1; step(8); sclk = 1'b0; step(8); end
      chk("R11 dout hold while cs high", dout, d0);
    end
    send_cmd({2'd0, 2'b11, 8'h11}, "R2 after idle clocks");

    // R9 general-purpose output and no-op
    send_cmd({2'd2, 2'b00, 8'h01}, "R9 upo set");
    send_cmd({2'd0, 2'b00, 8'hFF}, "R9 nop");
    send_cmd({2'd2, 2'b00, 8'h00}, "R9 upo clear");

    // R10 shutdown gating
    pde = 1'b0;
    send_cmd({2'd1, 2'b00, 8'h00}, "R10 shdn pde low");
    pde = 1'b1;
    step(4);
    send_cmd({2'd1, 2'b00, 8'h00}, "R10 shdn pde high");
    send_cmd({2'd0, 2'b01, 8'h22}, "R10 shdn cleared by load");

    // R7 ldac held low during a command
    ldac_n = 1'b0;
    send_cmd({2'd1, 2'b01, 8'h99}, "R7 ldac low command");
    ldac_n = 1'b1;
    step(6);
    // R7 ldac pulse after a plain load
    send_cmd({2'd2, 2'b01, 8'h44}, "R7 load before pulse");
    ldac_n = 1'b0;
    step(10);
    ldac_n = 1'b1;
    for (int i = 0; i < 4; i++) m_dac[i] = m_in[i];
    step(4);
    chk("R7 ldac pulse", dac_code, m_flat());

    // R8 asynchronous clear
    clr_n = 1'b0;
    #1;
    chk("R8 async clear", dac_code, 0);
    step(3);
    clr_n = 1'b1;
    for (int i = 0; i < 4; i++) begin m_in[i] = 8'h00; m_dac[i] = 8'h00; end
    step(4);
    send_cmd({2'd0, 2'b10, 8'hAA}, "R8 input latches cleared");

    // R11 / R12 falling-edge launch (default)
    w1 = {2'd1, 2'b01, 8'h6C};
    w2 = {2'd2, 2'b01, 8'h93};
    send_cmd(w1, "R11 chain word 1");
    send_cmd(w2, "R11 chain word 2");
    for (int k = 0; k < 12; k++) chk($sformatf("R11 fall pre-rise bit %0d", k), pre_s[k], w1[11-k]);
    for (int k = 0; k < 11; k++) chk($sformatf("R12 fall mid-high bit %0d", k), mid_s[k], w1[11-k]);

    // R12 switch to rising-edge launch
    send_cmd({2'd3, 2'b00, 8'h01}, "R12 edge select");
    send_cmd(w1, "R12 chain word 1");
    send_cmd(w2, "R12 chain word 2");
    for (int k = 0; k < 12; k++) chk($sformatf("R11 rise pre-rise bit %0d", k), pre_s[k], w1[11-k]);
    for (int k = 0; k < 11; k++) chk($sformatf("R12 rise mid-high bit %0d", k), mid_s[k], w1[10-k]);

    while (q.size() != 0) step(1);
    step(12);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule